// File: doc/BRIEF.md
# Processor Bus Stall and Wait Controller

This block sits between a small 8-bit processor core and its memory bus. On every cycle boundary it decides whether the bus cycle in progress completes or freezes. Boundaries are marked by a single-clock strobe on a rising-edge clock. A cycle completes only when the boundary strobe sees the ready input high and the bus enabled. It then hands the core's next request (address, read/write direction, write data) to the bus outputs. In every other case the outputs hold exactly what they showed before. This holds for write cycles as well as reads, so an external agent can step the core one bus cycle at a time by pulsing ready.

When the core executes its wait-for-interrupt operation on a completing cycle, the block pulls a dedicated active-low wait output low. The wait output does not gate the core by itself. It takes effect only when the system feeds it back into ready; without that loop the core keeps running. An interrupt request or non-maskable interrupt raises the wait output again on the next clock. The bus-enable input removes the address, direction and data drivers through their output enables and freezes all bus state while low.

Top module: `bus_stall_ctrl`

## Requirements
- R1: After synchronous reset, `adr_o` is 0, `rw_o` is 1 (read), `dat_o` is 0, `rd_data_o` is 0 and `wait_n_o` is 1.
- R2: `core_adv` is high in exactly those clocks where `cyc_stb`, `rdy_in` and `bus_en` are all high; each such clock completes one bus cycle.
- R3: On the clock after a completing strobe, `adr_o`, `rw_o` and `dat_o` equal the `core_addr`, `core_rw_n` and `core_wdata` presented with that strobe.
- R4: In any clock that does not complete a cycle (no strobe, ready low, or bus disabled), `adr_o`, `rw_o` and `dat_o` keep their values, for write cycles (`rw_o` = 0) as for reads (`rw_o` = 1).
- R5: When a read cycle (`rw_o` = 1) completes, `rd_data_o` takes `dat_i` on the next clock; otherwise it holds.
- R6: A completing strobe with `core_wai` high and neither `irq_req` nor `nmi_req` high drives `wait_n_o` low on the next clock; it stays low until an interrupt input is high.
- R7: Whenever `irq_req` or `nmi_req` is high, `wait_n_o` is 1 on the next clock, whatever the strobe, ready and bus-enable inputs are; the interrupt wins over a simultaneous wait request.
- R8: `wait_n_o` has no direct effect on stepping: with ready not looped back, cycles keep completing while `wait_n_o` is low; with `rdy_in` driven by ready AND `wait_n_o`, no cycle completes until an interrupt releases the wait.
- R9: While `bus_en` is low, `adr_oe`, `rw_oe` and `dat_oe` are low, no cycle completes, and the bus outputs and captured read data are unchanged.
- R10: `adr_oe` and `rw_oe` equal `bus_en`; `dat_oe` is high only when `bus_en` is high and the current cycle is a write (`rw_o` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | Cycle-boundary strobe, one clock wide |
| rdy_in | input | 1 | Ready; low at a boundary stalls the cycle |
| bus_en | input | 1 | Bus enable; low tri-states the bus and freezes state |
| irq_req | input | 1 | Maskable interrupt request, active high |
| nmi_req | input | 1 | Non-maskable interrupt request, active high |
| core_addr | input | 16 | Address of the core's next bus cycle |
| core_rw_n | input | 1 | Direction of the next cycle: 1 read, 0 write |
| core_wdata | input | 8 | Write data of the next cycle |
| core_wai | input | 1 | Core executes wait-for-interrupt with this cycle |
| dat_i | input | 8 | Read data from the bus |
| core_adv | output | 1 | Current bus cycle completes in this clock |
| adr_o | output | 16 | Bus address of the cycle in progress |
| adr_oe | output | 1 | Address output enable |
| rw_o | output | 1 | Bus direction: 1 read, 0 write |
| rw_oe | output | 1 | Direction output enable |
| dat_o | output | 8 | Write data on the bus |
| dat_oe | output | 1 | Data output enable |
| rd_data_o | output | 8 | Data captured at the end of the last read cycle |
| wait_n_o | output | 1 | Wait-for-interrupt indication, active low |

## Verification
A corrupted cycle register shows at once on `adr_o`, `rw_o` or `dat_o`, one clock after the strobe that loaded it, or as drift during a stall that should have held. A wrong step decision shows in the same clock on `core_adv` and one clock later as bus outputs that moved or failed to move. A wait flag in the wrong state appears on `wait_n_o` the clock after the offending strobe or interrupt. With ready looped back, it also appears as cycles that complete when they should freeze, or the reverse. The reference model is compared on every clock, so any of these faults is reported within one or two clocks of its cause.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_RST = '0;
    localparam logic [DATA_W-1:0] DATA_RST = '0;

    // direction encoding on the bus
    localparam logic DIR_READ  = 1'b1;
    localparam logic DIR_WRITE = 1'b0;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rw_n;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    localparam bus_req_t REQ_RST = '{addr: ADDR_RST, rw_n: DIR_READ, wdata: DATA_RST};

    function automatic logic is_write(input bus_req_t r);
        return r.rw_n == DIR_WRITE;
    endfunction

    function automatic logic boundary_done(input logic stb, input logic rdy, input logic en);
        return stb & rdy & en;
    endfunction

endpackage

// File: rtl/bsc_step_gate.sv
module bsc_step_gate
    import bsc_pkg::*;
(
    input  logic cyc_stb,
    input  logic rdy_in,
    input  logic bus_en,
    output logic step
);
    always_comb begin
        step = boundary_done(cyc_stb, rdy_in, bus_en);
    end
endmodule

// File: rtl/bsc_cycle_hold.sv
module bsc_cycle_hold
    import bsc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     step,
    input  bus_req_t next_req,
    output bus_req_t cur_req
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_req <= REQ_RST;
        end else if (step) begin
            cur_req <= next_req;
        end
    end
endmodule

// File: rtl/bsc_wait_ctl.sv
module bsc_wait_ctl (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic wai_req,
    input  logic irq_req,
    input  logic nmi_req,
    output logic wait_n
);
    logic release_now;

    always_comb begin
        release_now = irq_req | nmi_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_n <= 1'b1;
        end else if (release_now) begin
            wait_n <= 1'b1;
        end else if (step && wai_req) begin
            wait_n <= 1'b0;
        end
    end
endmodule

// File: rtl/bsc_read_cap.sv
module bsc_read_cap
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              cur_is_read,
    input  logic [DATA_W-1:0] dat_i,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= DATA_RST;
        end else if (step && cur_is_read) begin
            rd_data <= dat_i;
        end
    end
endmodule

// File: rtl/bus_stall_ctrl.sv
module bus_stall_ctrl
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_stb,
    input  logic              rdy_in,
    input  logic              bus_en,
    input  logic              irq_req,
    input  logic              nmi_req,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_rw_n,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_wai,
    input  logic [DATA_W-1:0] dat_i,
    output logic              core_adv,
    output logic [ADDR_W-1:0] adr_o,
    output logic              adr_oe,
    output logic              rw_o,
    output logic              rw_oe,
    output logic [DATA_W-1:0] dat_o,
    output logic              dat_oe,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wait_n_o
);
    logic     step;
    bus_req_t next_req;
    bus_req_t cur_req;

    always_comb begin
        next_req.addr  = core_addr;
        next_req.rw_n  = core_rw_n;
        next_req.wdata = core_wdata;
    end

    bsc_step_gate u_gate (
        .cyc_stb (cyc_stb),
        .rdy_in  (rdy_in),
        .bus_en  (bus_en),
        .step    (step)
    );

    bsc_cycle_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .step     (step),
        .next_req (next_req),
        .cur_req  (cur_req)
    );

    bsc_wait_ctl u_wait (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .wai_req (core_wai),
        .irq_req (irq_req),
        .nmi_req (nmi_req),
        .wait_n  (wait_n_o)
    );

    bsc_read_cap u_rcap (
        .clk         (clk),
        .rst         (rst),
        .step        (step),
        .cur_is_read (~is_write(cur_req)),
        .dat_i       (dat_i),
        .rd_data     (rd_data_o)
    );

    always_comb begin
        core_adv = step;
        adr_o    = cur_req.addr;
        rw_o     = cur_req.rw_n;
        dat_o    = cur_req.wdata;
        adr_oe   = bus_en;
        rw_oe    = bus_en;
        dat_oe   = bus_en & is_write(cur_req);
    end
endmodule

// File: rtl/bus_stall_ctrl_chk.sv
module bus_stall_ctrl_chk
    import bsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_stb,
    input  logic              rdy_in,
    input  logic              bus_en,
    input  logic              irq_req,
    input  logic              nmi_req,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic              core_rw_n,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              core_wai,
    input  logic [DATA_W-1:0] dat_i,
    input  logic              core_adv,
    input  logic [ADDR_W-1:0] adr_o,
    input  logic              adr_oe,
    input  logic              rw_o,
    input  logic              rw_oe,
    input  logic [DATA_W-1:0] dat_o,
    input  logic              dat_oe,
    input  logic [DATA_W-1:0] rd_data_o,
    input  logic              wait_n_o
);
    // R2
    adv_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        core_adv |-> (cyc_stb && rdy_in && bus_en));

    // R3
    load_on_step_chk: assert property (@(posedge clk) disable iff (rst)
        core_adv |=> (adr_o == $past(core_addr) && rw_o == $past(core_rw_n)
                      && dat_o == $past(core_wdata)));

    // R4
    hold_when_stalled_chk: assert property (@(posedge clk) disable iff (rst)
        !(cyc_stb && rdy_in && bus_en) |=> ($stable(adr_o) && $stable(rw_o) && $stable(dat_o)));

    // R5
    read_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (core_adv && rw_o) |=> rd_data_o == $past(dat_i));

    // R6
    wait_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (core_adv && core_wai && !irq_req && !nmi_req) |=> !wait_n_o);

    // R6
    wait_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!wait_n_o && !irq_req && !nmi_req) |=> !wait_n_o);

    // R7
    wait_release_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req || nmi_req) |=> wait_n_o);

    // R9
    disabled_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_en |=> ($stable(rd_data_o) && $stable(adr_o)));

    // R10
    data_drive_write_chk: assert property (@(posedge clk) disable iff (rst)
        dat_oe |-> (!rw_o && adr_oe && rw_oe));

    // R9
    disabled_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_en |-> (!adr_oe && !rw_oe && !dat_oe && !core_adv));
endmodule

bind bus_stall_ctrl bus_stall_ctrl_chk u_chk (.*);

// File: tb/bus_stall_ctrl_bench.sv
module bus_stall_ctrl_bench;
    import bsc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic              cyc_stb = 0, ext_rdy = 0, bus_en = 0, irq_req = 0, nmi_req = 0;
    logic [ADDR_W-1:0] core_addr = '0;
    logic              core_rw_n = 1'b1;
    logic [DATA_W-1:0] core_wdata = '0, dat_i = '0;
    logic              core_wai = 0, loop_en = 0;
    logic              rdy_in;
    logic              core_adv, adr_oe, rw_o, rw_oe, dat_oe, wait_n_o;
    logic [ADDR_W-1:0] adr_o;
    logic [DATA_W-1:0] dat_o, rd_data_o;

    // ready, optionally looped back through the wait output
    assign rdy_in = ext_rdy & (loop_en ? wait_n_o : 1'b1);

    bus_stall_ctrl u_bus_stall_ctrl (.*);

    // reference state
    int unsigned m_addr, m_rw, m_wd, m_rd, m_wait;
    int n_chk = 0, n_fail = 0;
    int strobes_ok = 0, advs = 0;
    bit done = 0;

    task automatic chk(input string tag, input string what, input int unsigned act, input int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // one clock: drive after negedge, check combinational, advance model, check registered
    task automatic cyc(input bit stb, input bit r, input bit en, input bit wai,
                       input bit irq, input bit nmi, input int unsigned a,
                       input bit rwn, input int unsigned wd, input int unsigned di);
        int unsigned m_rdy, m_step;
        cyc_stb = stb; ext_rdy = r; bus_en = en; core_wai = wai;
        irq_req = irq; nmi_req = nmi; core_addr = a[ADDR_W-1:0];
        core_rw_n = rwn; core_wdata = wd[DATA_W-1:0]; dat_i = di[DATA_W-1:0];
        #1;
        m_rdy  = r & (loop_en ? m_wait : 1);
        m_step = stb & m_rdy & en;
        if (stb && rdy_in && en) strobes_ok++;
        if (core_adv) advs++;
        chk("R2", "core_adv", core_adv, m_step);
        chk("R10", "adr_oe", adr_oe, en);
        chk("R10", "rw_oe", rw_oe, en);
        chk(en ? "R10" : "R9", "dat_oe", dat_oe, en & (m_rw == 0));
        @(posedge clk);
        if (m_step) begin
            if (m_rw == 1) m_rd = di & 8'hff;
            m_addr = a & 16'hffff; m_rw = rwn; m_wd = wd & 8'hff;
        end
        if (irq || nmi) m_wait = 1;
        else if (m_step && wai) m_wait = 0;
        @(negedge clk);
        chk(m_step ? "R3" : "R4", "adr_o", adr_o, m_addr);
        chk(m_step ? "R3" : "R4", "rw_o", rw_o, m_rw);
        chk(m_step ? "R3" : "R4", "dat_o", dat_o, m_wd);
        chk("R5", "rd_data_o", rd_data_o, m_rd);
        chk((irq || nmi) ? "R7" : "R6", "wait_n_o", wait_n_o, m_wait);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_addr = 0; m_rw = 1; m_wd = 0; m_rd = 0; m_wait = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "adr_o", adr_o, 0);
        chk("R1", "rw_o", rw_o, 1);
        chk("R1", "dat_o", dat_o, 0);
        chk("R1", "rd_data_o", rd_data_o, 0);
        chk("R1", "wait_n_o", wait_n_o, 1);

        // R3 load a write cycle, then R4 stall it with ready low and changing requests
        cyc(1, 1, 1, 0, 0, 0, 16'h1234, 0, 8'hA5, 8'h00);
        for (int i = 0; i < 6; i++) cyc(i % 2, 0, 1, 0, 0, 0, 16'h4000 + i, 1, i, 8'h3C);
        chk("R4", "write held adr", adr_o, 16'h1234);
        chk("R4", "write held data", dat_o, 8'hA5);
        chk("R10", "write drives data", dat_oe, 1);
        // single-step: one ready-high strobe advances exactly once
        cyc(1, 1, 1, 0, 0, 0, 16'h2000, 1, 8'h00, 8'h77);
        cyc(1, 1, 1, 0, 0, 0, 16'h2001, 1, 8'h00, 8'h5A);
        chk("R5", "read captured", rd_data_o, 8'h5A);

        // R8 wait without loopback: core keeps stepping
        loop_en = 0;
        cyc(1, 1, 1, 1, 0, 0, 16'h3000, 1, 0, 0);
        chk("R6", "wait low", wait_n_o, 0);
        cyc(1, 1, 1, 0, 0, 0, 16'h3001, 1, 0, 0);
        chk("R8", "stepped while wait low", adr_o, 16'h3001);
        cyc(0, 0, 1, 0, 1, 0, 16'h3002, 1, 0, 0);
        chk("R7", "irq releases", wait_n_o, 1);

        // R8 with loopback: frozen until nmi
        loop_en = 1;
        cyc(1, 1, 1, 1, 0, 0, 16'h3100, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0, 0, 0, 16'h3200 + i, 1, 0, 0);
        chk("R8", "looped wait freezes", adr_o, 16'h3100);
        // R7 interrupt wins over simultaneous wait request, released while bus disabled
        cyc(1, 1, 0, 1, 0, 1, 16'h3300, 1, 0, 0);
        chk("R7", "nmi releases while disabled", wait_n_o, 1);
        cyc(1, 1, 1, 1, 1, 0, 16'h3400, 1, 0, 0);
        chk("R7", "irq beats wai", wait_n_o, 1);

        // R9 bus disabled: no step, no drive
        for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 0, 0, 16'h5000 + i, 0, 8'hEE, 8'h11);
        chk("R9", "frozen adr", adr_o, 16'h3400);

        // random stretches of ready low, with loopback
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 10) != 0,
                ($urandom % 25) == 0, ($urandom % 30) == 0, ($urandom % 60) == 0,
                $urandom, $urandom % 2, $urandom, $urandom);
            if (i == 2000) loop_en = 0;
        end
        chk("R2", "cycles per ready-high strobe", advs, strobes_ok);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule